// File: doc/BRIEF.md
# Full-Duplex Serial Port with Strobed Byte Bus

This block connects a byte-wide processor bus to a pair of asynchronous serial lines. The processor selects the block with an active-low chip select and then uses either an active-low write enable or an active-low output enable. A write hands one byte to the transmitter. A read takes the oldest received byte from a single-entry receive buffer. During a read strobe the byte is driven onto the bidirectional data port. After the strobe it is also held on a registered read-data output.

Three configuration inputs set the frame shape: a 7-bit or 8-bit data length, whether a parity bit is present, and whether that parity is odd or even. Bit timing comes from a fixed clocks-per-bit divider. Four status outputs report the following conditions:

- the transmitter can accept a byte;
- a byte is waiting to be read;
- the waiting byte arrived with bad parity;
- a later frame was lost because the buffer was still full.

Top module: `uart_strobe_port`

## Requirements
- R1: After reset, tx_ready is 1, rx_ready, par_err and overrun are 0, and txd idles at 1.
- R2: A write happens on the first clock in which cs_n and we_n are both low while tx_ready is 1. At that clock the byte on data_io is taken, tx_ready drops to 0 and txd goes low for the start bit.
- R3: A write strobe seen while tx_ready is 0 is ignored. No frame is sent for that byte.
- R4: A frame has these parts in order: one low start bit, then 7 or 8 data bits with bit 0 first, then a parity bit if cfg_par_en is 1, then one high stop bit. Each bit lasts CLKS_PER_BIT clocks. cfg_wide=1 selects 8 data bits.
- R5: rx_ready rises when the stop bit of a received frame is sampled. It stays at 1 until a read happens, and the read clears it.
- R6: A read happens on the first clock in which cs_n and oe_n are both low with we_n high. While the strobes are low, data_io carries the buffered byte. After that clock edge, rd_data holds the same byte until the next read.
- R7: When cfg_wide is 0, bit 7 of a written byte is not sent, and bit 7 of a received byte reads as 0.
- R8: When parity is enabled, the parity bit makes the number of ones over the data bits and the parity bit even if cfg_par_odd=0, or odd if cfg_par_odd=1. par_err is set together with rx_ready when the received parity bit does not match this rule, and stays 0 when it does.
- R9: overrun is 1 only after a further frame completes while a byte is still unread. The unread byte is kept and the new byte is dropped.
- R10: A read clears overrun and par_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable (read strobe) |
| we_n | input | 1 | Active-low write enable (write strobe) |
| data_io | inout | 8 | Bidirectional data; the block drives it only during a read strobe |
| rd_data | output | 8 | Byte taken by the most recent read, held |
| cfg_wide | input | 1 | 1 selects 8 data bits, 0 selects 7 |
| cfg_par_en | input | 1 | 1 adds a parity bit to each frame |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| txd | output | 1 | Serial transmit line, idles high |
| rxd | input | 1 | Serial receive line, idles high |
| tx_ready | output | 1 | Transmitter can accept a byte |
| rx_ready | output | 1 | A received byte is waiting |
| par_err | output | 1 | The waiting byte had a parity mismatch |
| overrun | output | 1 | A frame was lost because the buffer was full |

## Verification
A wrong transmit phase shows within one bit time. Either tx_ready fails to drop at the write, or txd leaves its idle level at the wrong moment. A shifted bit or a mis-aligned 7-bit byte reaches the ports only about one frame later, when the looped-back byte is read and compared. Faults in the receive buffer show the moment a second frame completes: a lost first byte, an early or missing overrun, or a parity flag that survives a read. The bench therefore reads back the byte and all flags after every frame.

// File: rtl/uart_sp_pkg.sv
package uart_sp_pkg;

  localparam int BYTE_W = 8;

  typedef struct packed {
    logic wide;
    logic par_en;
    logic par_odd;
  } frame_cfg_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } phase_t;

  // Parity bit over the active data bits: even -> XOR, odd -> XNOR.
  function automatic logic calc_parity(input logic [BYTE_W-1:0] d,
                                       input logic wide,
                                       input logic odd);
    logic p;
    p = ^(wide ? d : {1'b0, d[BYTE_W-2:0]});
    return p ^ odd;
  endfunction

endpackage

// File: rtl/uart_sp_tx.sv
module uart_sp_tx
  import uart_sp_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  frame_cfg_t        cfg,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic              ready,
  output logic              txd
);

  localparam int CNT_W = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CLKS_PER_BIT - 1);

  phase_t            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [2:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  logic              txd_q, txd_d;
  logic              tick;
  logic [2:0]        last_bit;

  assign tick     = (cnt_q == LAST_CNT);
  assign last_bit = cfg.wide ? 3'd7 : 3'd6;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    par_d   = par_q;
    txd_d   = txd_q;
    unique case (phase_q)
      PH_IDLE: begin
        txd_d = 1'b1;
        if (load) begin
          sh_d    = cfg.wide ? din : {1'b0, din[BYTE_W-2:0]};
          par_d   = calc_parity(din, cfg.wide, cfg.par_odd);
          cnt_d   = '0;
          phase_d = PH_START;
          txd_d   = 1'b0;
        end
      end
      PH_START: begin
        cnt_d = cnt_q + 1'b1;
        if (tick) begin
          cnt_d   = '0;
          bit_d   = '0;
          phase_d = PH_DATA;
          txd_d   = sh_q[0];
        end
      end
      PH_DATA: begin
        cnt_d = cnt_q + 1'b1;
        if (tick) begin
          cnt_d = '0;
          if (bit_q == last_bit) begin
            if (cfg.par_en) begin
              phase_d = PH_PAR;
              txd_d   = par_q;
            end else begin
              phase_d = PH_STOP;
              txd_d   = 1'b1;
            end
          end else begin
            bit_d = bit_q + 1'b1;
            sh_d  = sh_q >> 1;
            txd_d = sh_q[1];
          end
        end
      end
      PH_PAR: begin
        cnt_d = cnt_q + 1'b1;
        if (tick) begin
          cnt_d   = '0;
          phase_d = PH_STOP;
          txd_d   = 1'b1;
        end
      end
      PH_STOP: begin
        cnt_d = cnt_q + 1'b1;
        if (tick) begin
          cnt_d   = '0;
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      txd_q   <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      txd_q   <= txd_d;
    end
  end

  assign ready = (phase_q == PH_IDLE);
  assign txd   = txd_q;

  // R2
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ready) |=> !ready);

  // R4
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> txd_q);

endmodule

// File: rtl/uart_sp_rx.sv
module uart_sp_rx
  import uart_sp_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  frame_cfg_t        cfg,
  input  logic              rxd,
  output logic              done,
  output logic [BYTE_W-1:0] dout,
  output logic              perr
);

  localparam int CNT_W = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(CLKS_PER_BIT / 2 - 1);

  logic [1:0]        sync_q;
  logic              rx_s;
  phase_t            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [2:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              pbit_q, pbit_d;
  logic              done_q, done_d;
  logic [BYTE_W-1:0] dout_q, dout_d;
  logic              perr_q, perr_d;
  logic              tick;
  logic [2:0]        last_bit;
  logic [BYTE_W-1:0] aligned;

  assign rx_s     = sync_q[1];
  assign tick     = (cnt_q == LAST_CNT);
  assign last_bit = cfg.wide ? 3'd7 : 3'd6;
  assign aligned  = cfg.wide ? sh_q : {1'b0, sh_q[BYTE_W-1:1]};

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    pbit_d  = pbit_q;
    done_d  = 1'b0;
    dout_d  = dout_q;
    perr_d  = perr_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (!rx_s) begin
          cnt_d   = '0;
          phase_d = PH_START;
        end
      end
      PH_START: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == MID_CNT) begin
          cnt_d   = '0;
          bit_d   = '0;
          phase_d = rx_s ? PH_IDLE : PH_DATA;
        end
      end
      PH_DATA: begin
        cnt_d = cnt_q + 1'b1;
        if (tick) begin
          cnt_d = '0;
          sh_d  = {rx_s, sh_q[BYTE_W-1:1]};
          if (bit_q == last_bit) phase_d = cfg.par_en ? PH_PAR : PH_STOP;
          else                   bit_d   = bit_q + 1'b1;
        end
      end
      PH_PAR: begin
        cnt_d = cnt_q + 1'b1;
        if (tick) begin
          cnt_d   = '0;
          pbit_d  = rx_s;
          phase_d = PH_STOP;
        end
      end
      PH_STOP: begin
        cnt_d = cnt_q + 1'b1;
        if (tick) begin
          cnt_d   = '0;
          phase_d = PH_IDLE;
          done_d  = 1'b1;
          dout_d  = aligned;
          perr_d  = cfg.par_en &&
                    (pbit_q != calc_parity(aligned, cfg.wide, cfg.par_odd));
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
      done_q  <= 1'b0;
      dout_q  <= '0;
      perr_q  <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], rxd};
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      pbit_q  <= pbit_d;
      done_q  <= done_d;
      dout_q  <= dout_d;
      perr_q  <= perr_d;
    end
  end

  assign done = done_q;
  assign dout = dout_q;
  assign perr = perr_q;

  // R7
  narrow_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !cfg.wide) |-> !dout_q[BYTE_W-1]);

endmodule

// File: rtl/uart_sp_rxhold.sv
module uart_sp_rxhold
  import uart_sp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [BYTE_W-1:0] din,
  input  logic              perr_in,
  input  logic              rd,
  output logic [BYTE_W-1:0] hold_byte,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              ready,
  output logic              perr,
  output logic              overrun
);

  logic [BYTE_W-1:0] buf_q, buf_d;
  logic [BYTE_W-1:0] rdb_q, rdb_d;
  logic              rdy_q, rdy_d;
  logic              perr_q, perr_d;
  logic              ovr_q, ovr_d;

  always_comb begin
    buf_d  = buf_q;
    rdb_d  = rdb_q;
    rdy_d  = rdy_q;
    perr_d = perr_q;
    ovr_d  = ovr_q;
    if (rd) begin
      rdb_d  = buf_q;
      rdy_d  = 1'b0;
      perr_d = 1'b0;
      ovr_d  = 1'b0;
    end
    if (done) begin
      if (rdy_q && !rd) begin
        ovr_d = 1'b1;
      end else begin
        buf_d  = din;
        rdy_d  = 1'b1;
        perr_d = perr_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      rdb_q  <= '0;
      rdy_q  <= 1'b0;
      perr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      rdb_q  <= rdb_d;
      rdy_q  <= rdy_d;
      perr_q <= perr_d;
      ovr_q  <= ovr_d;
    end
  end

  assign hold_byte = buf_q;
  assign rd_byte   = rdb_q;
  assign ready     = rdy_q;
  assign perr      = perr_q;
  assign overrun   = ovr_q;

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(rdy_q));

  // R9
  keep_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && !rd) |=> (rdy_q && $stable(buf_q)));

  // R10
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !done) |=> (!ovr_q && !perr_q && !rdy_q));

endmodule

// File: rtl/uart_strobe_port.sv
module uart_strobe_port
  import uart_sp_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       oe_n,
  input  logic       we_n,
  inout  wire  [7:0] data_io,
  output logic [7:0] rd_data,
  input  logic       cfg_wide,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  output logic       txd,
  input  logic       rxd,
  output logic       tx_ready,
  output logic       rx_ready,
  output logic       par_err,
  output logic       overrun
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              wr_act, rd_act;
  logic              wr_prev_q, rd_prev_q;
  logic              wr_pulse, rd_pulse;
  frame_cfg_t        cfg;
  logic              rx_done, rx_perr;
  logic [BYTE_W-1:0] rx_byte, hold_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign cfg    = '{wide: cfg_wide, par_en: cfg_par_en, par_odd: cfg_par_odd};
  assign wr_act = !cs_n && !we_n;
  assign rd_act = !cs_n && !oe_n && we_n;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wr_prev_q <= 1'b0;
      rd_prev_q <= 1'b0;
    end else begin
      wr_prev_q <= wr_act;
      rd_prev_q <= rd_act;
    end
  end

  assign wr_pulse = wr_act && !wr_prev_q;
  assign rd_pulse = rd_act && !rd_prev_q;

  assign data_io = rd_act ? hold_byte : 8'bz;

  uart_sp_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk   (clk),
    .rst_n (rst_n_s),
    .cfg   (cfg),
    .load  (wr_pulse),
    .din   (data_io),
    .ready (tx_ready),
    .txd   (txd)
  );

  uart_sp_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk   (clk),
    .rst_n (rst_n_s),
    .cfg   (cfg),
    .rxd   (rxd),
    .done  (rx_done),
    .dout  (rx_byte),
    .perr  (rx_perr)
  );

  uart_sp_rxhold u_hold (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .done      (rx_done),
    .din       (rx_byte),
    .perr_in   (rx_perr),
    .rd        (rd_pulse),
    .hold_byte (hold_byte),
    .rd_byte   (rd_data),
    .ready     (rx_ready),
    .perr      (par_err),
    .overrun   (overrun)
  );

  // R6
  bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_pulse |=> (rd_data == $past(hold_byte)));

endmodule

// File: tb/sim_uart_strobe_port.sv
`timescale 1ns/1ps
module sim_uart_strobe_port;

  localparam int CPB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic       bus_drv = 1'b0;
  logic [7:0] bus_val = 8'h00;
  wire  [7:0] data_io;
  logic [7:0] rd_data;
  logic       cfg_wide = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic       txd, rxd, tx_ready, rx_ready, par_err, overrun;
  logic       use_loop = 1'b1;
  logic       raw_rx = 1'b1;
  int         n_tests = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  assign data_io = bus_drv ? bus_val : 8'bz;
  assign rxd     = use_loop ? txd : raw_rx;

  uart_strobe_port #(.CLKS_PER_BIT(CPB)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .data_io(data_io), .rd_data(rd_data),
    .cfg_wide(cfg_wide), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .txd(txd), .rxd(rxd), .tx_ready(tx_ready), .rx_ready(rx_ready),
    .par_err(par_err), .overrun(overrun)
  );

  // {cfg wide/par_en/par_odd, byte written, byte expected back}
  localparam logic [18:0] VEC [0:5] = '{
    {3'b100, 8'hA5, 8'hA5},
    {3'b110, 8'h3C, 8'h3C},
    {3'b111, 8'h81, 8'h81},
    {3'b000, 8'hFF, 8'h7F},
    {3'b010, 8'hC5, 8'h45},
    {3'b011, 8'h00, 8'h00}
  };

  task automatic check(input string req, input int got, input int exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] b);
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b0; bus_drv = 1'b1; bus_val = b;
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1; bus_drv = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] exp, input string req);
    @(negedge clk);
    cs_n = 1'b0; oe_n = 1'b0;
    #1;
    check({req, " data_io during read"}, int'(data_io), int'(exp));
    @(negedge clk);
    cs_n = 1'b1; oe_n = 1'b1;
    repeat (2) @(negedge clk);
    check({req, " rd_data after read"}, int'(rd_data), int'(exp));
    check("R5 rx_ready cleared by read", int'(rx_ready), 0);
  endtask

  task automatic wait_rx(input string req);
    int n = 0;
    while (!rx_ready && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check({req, " rx_ready seen"}, int'(rx_ready), 1);
  endtask

  task automatic wait_txr();
    int n = 0;
    while (!tx_ready && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic send_raw(input logic [7:0] d, input int nbits,
                          input logic has_par, input logic pbit);
    @(negedge clk);
    raw_rx = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      raw_rx = d[i];
      repeat (CPB) @(negedge clk);
    end
    if (has_par) begin
      raw_rx = pbit;
      repeat (CPB) @(negedge clk);
    end
    raw_rx = 1'b1;
    repeat (2 * CPB) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 tx_ready", int'(tx_ready), 1);
    check("R1 rx_ready", int'(rx_ready), 0);
    check("R1 par_err", int'(par_err), 0);
    check("R1 overrun", int'(overrun), 0);
    check("R1 txd idle", int'(txd), 1);

    // Table walk through loopback: R4 framing, R7 narrow mode, R8 matching parity
    for (int i = 0; i < 6; i++) begin
      {cfg_wide, cfg_par_en, cfg_par_odd} = VEC[i][18:16];
      repeat (4) @(negedge clk);
      do_write(VEC[i][15:8]);
      check("R2 tx_ready drops at write", int'(tx_ready), 0);
      check("R2 start bit on txd", int'(txd), 0);
      wait_rx("R4");
      check("R8 no parity error on match", int'(par_err), 0);
      do_read(VEC[i][7:0], "R4/R7 loopback byte");
      wait_txr();
      repeat (CPB) @(negedge clk);
    end

    // R3: write while busy is ignored
    {cfg_wide, cfg_par_en, cfg_par_odd} = 3'b100;
    do_write(8'h11);
    repeat (3) @(negedge clk);
    do_write(8'h22);
    wait_rx("R3");
    do_read(8'h11, "R3 first byte kept");
    repeat (400) @(negedge clk);
    check("R3 no frame for ignored write", int'(rx_ready), 0);

    // R9: overflow keeps oldest, not set after a single byte
    do_write(8'h5A);
    wait_txr();
    do_write(8'hC3);
    wait_rx("R9");
    check("R9 no overrun with one byte", int'(overrun), 0);
    begin
      int n = 0;
      while (!overrun && n < 600) begin
        @(negedge clk);
        n++;
      end
    end
    check("R9 overrun after second frame", int'(overrun), 1);
    check("R9 rx_ready still set", int'(rx_ready), 1);
    do_read(8'h5A, "R9 oldest byte returned");
    check("R10 overrun cleared by read", int'(overrun), 0);

    // R8: bad parity, even mode (0x5A has four ones, correct bit is 0)
    use_loop = 1'b1;
    repeat (4) @(negedge clk);
    use_loop = 1'b0;
    {cfg_wide, cfg_par_en, cfg_par_odd} = 3'b110;
    send_raw(8'h5A, 8, 1'b1, 1'b1);
    check("R8 even parity mismatch flagged", int'(par_err), 1);
    check("R8 rx_ready with parity error", int'(rx_ready), 1);
    do_read(8'h5A, "R8 byte with bad parity");
    check("R10 par_err cleared by read", int'(par_err), 0);

    // R8: bad parity, odd mode (correct bit for 0x5A is 1)
    cfg_par_odd = 1'b1;
    send_raw(8'h5A, 8, 1'b1, 1'b0);
    check("R8 odd parity mismatch flagged", int'(par_err), 1);
    do_read(8'h5A, "R8 odd byte");

    // R8/R7: correct odd parity in 7-bit mode on raw line (0x35: four ones -> bit 1)
    cfg_wide = 1'b0;
    send_raw(8'h35, 7, 1'b1, 1'b1);
    check("R8 odd parity match clean", int'(par_err), 0);
    do_read(8'h35, "R7 narrow raw byte");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule